// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block holds the program counter of a 32-bit single-cycle core and picks the address of the next instruction every clock. It looks at the fetched instruction word together with the two source register values that the register file has already read for it. From these it decides whether control falls through, jumps to an absolute target, jumps to a register value, or takes a conditional branch on an equality or sign test. It then loads that address into the PC on the next rising edge.

For the call instruction the block also supplies a write request for the link register: an enable, the fixed destination index 31, and the return address, which is the current PC plus 8. The register file consumes these in the same cycle. Absolute jump targets keep the top four bits of the incremented PC, so absolute jumps stay inside the 256 MB region that PC+4 lies in.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low the PC holds `START_ADDR` (default 0x0040_0000), and it still holds that value after reset is released until the first rising edge with `rst_n` high.
- R2: An instruction that is not a control instruction advances the PC by 4. The opcode is bits 31:26. Opcodes other than 0x1 to 0x7 are not control instructions, and neither is opcode 0x0 with a function field (bits 5:0) other than 0x08. Opcode 0x1 with an rt field (bits 20:16) other than 0 or 1 is not a control instruction either.
- R3: Opcode 0x2 loads the PC with bits 31:28 of PC+4, then the 26-bit target field (bits 25:0), then two zero bits.
- R4: Opcode 0x3 loads the PC with the same target as R3. In that cycle `link_we` is 1, `link_idx` is 31 and `link_val` is PC+8. For every other instruction `link_we` is 0.
- R5: Opcode 0x0 with function 0x08 loads the PC with `rs_val`.
- R6: Opcode 0x4 is taken when `rs_val` equals `rt_val`, and opcode 0x5 is taken when they differ. A taken branch loads PC+4 plus the sign-extended 16-bit offset (bits 15:0) shifted left by 2.
- R7: Opcode 0x1 with rt field 0 is taken when `rs_val` is negative as a signed value. Opcode 0x1 with rt field 1 is taken when `rs_val` is zero or positive. The target is the one from R6.
- R8: Opcode 0x6 is taken when signed `rs_val` is less than or equal to zero. Opcode 0x7 is taken when signed `rs_val` is greater than zero. The target is the one from R6.
- R9: A conditional branch whose condition fails loads PC+4.
- R10: The region bits of an absolute jump come from PC+4 and not from PC. A jump issued at 0x2FFFFFFC therefore lands in region 0x3, and a jump issued at 0x2FFFFFF8 lands in region 0x2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads the start address |
| instr | input | 32 | Instruction fetched at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Link register write enable, high for the call instruction only |
| link_idx | output | 5 | Index of the link register (31) |
| link_val | output | 32 | Return address, PC+8 |

## Verification
The hardest case to reach is the region boundary. It needs the PC to sit exactly at 0x2FFFFFFC, where PC and PC+4 have different top four bits. The bench gets there without a reset address in that range by first issuing a register jump with `rs_val` set to the wanted address. It then issues an absolute jump and checks which region it lands in. The same register-jump step sets up each branch scenario from a known PC, and negative offsets and the most negative `rs_val` are used to exercise sign extension and signed comparison.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int INSN_W    = 32;
  localparam int OPC_W     = 6;
  localparam int FUNC_W    = 6;
  localparam int REG_IDX_W = 5;
  localparam int TGT_W     = 26;
  localparam int IMM_W     = 16;
  localparam int WORD_SHIFT = 2;

  localparam logic [OPC_W-1:0] OP_REG_GRP   = 6'h00;
  localparam logic [OPC_W-1:0] OP_SIGN_GRP  = 6'h01;
  localparam logic [OPC_W-1:0] OP_JUMP      = 6'h02;
  localparam logic [OPC_W-1:0] OP_JUMP_LINK = 6'h03;
  localparam logic [OPC_W-1:0] OP_BR_EQ     = 6'h04;
  localparam logic [OPC_W-1:0] OP_BR_NE     = 6'h05;
  localparam logic [OPC_W-1:0] OP_BR_LEZ    = 6'h06;
  localparam logic [OPC_W-1:0] OP_BR_GTZ    = 6'h07;

  localparam logic [FUNC_W-1:0]    FN_JREG = 6'h08;
  localparam logic [REG_IDX_W-1:0] SUB_LTZ = 5'd0;
  localparam logic [REG_IDX_W-1:0] SUB_GEZ = 5'd1;

  typedef enum logic [3:0] {
    FLOW_SEQ,
    FLOW_JABS,
    FLOW_JLINK,
    FLOW_JREG,
    FLOW_BEQ,
    FLOW_BNE,
    FLOW_BLTZ,
    FLOW_BGEZ,
    FLOW_BLEZ,
    FLOW_BGTZ
  } flow_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output flow_e             kind,
  output logic [TGT_W-1:0]  tgt,
  output logic [IMM_W-1:0]  imm
);

  logic [OPC_W-1:0]     opc;
  logic [FUNC_W-1:0]    fn;
  logic [REG_IDX_W-1:0] sub;

  assign opc = instr[INSN_W-1 -: OPC_W];
  assign fn  = instr[FUNC_W-1:0];
  assign sub = instr[IMM_W +: REG_IDX_W];
  assign tgt = instr[TGT_W-1:0];
  assign imm = instr[IMM_W-1:0];

  always_comb begin
    kind = FLOW_SEQ;
    case (opc)
      OP_REG_GRP: begin
        if (fn == FN_JREG) kind = FLOW_JREG;
      end
      OP_SIGN_GRP: begin
        if (sub == SUB_LTZ)      kind = FLOW_BLTZ;
        else if (sub == SUB_GEZ) kind = FLOW_BGEZ;
      end
      OP_JUMP:      kind = FLOW_JABS;
      OP_JUMP_LINK: kind = FLOW_JLINK;
      OP_BR_EQ:     kind = FLOW_BEQ;
      OP_BR_NE:     kind = FLOW_BNE;
      OP_BR_LEZ:    kind = FLOW_BLEZ;
      OP_BR_GTZ:    kind = FLOW_BGTZ;
      default:      kind = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e            kind,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic             taken
);

  logic is_neg;
  logic is_zero;
  logic is_eq;

  assign is_neg  = rs_val[XLEN-1];
  assign is_zero = (rs_val == '0);
  assign is_eq   = (rs_val == rt_val);

  always_comb begin
    case (kind)
      FLOW_BEQ:  taken = is_eq;
      FLOW_BNE:  taken = !is_eq;
      FLOW_BLTZ: taken = is_neg;
      FLOW_BGEZ: taken = !is_neg;
      FLOW_BLEZ: taken = is_neg | is_zero;
      FLOW_BGTZ: taken = !is_neg & !is_zero;
      default:   taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  pc,
  input  flow_e            kind,
  input  logic             taken,
  input  logic [TGT_W-1:0] tgt,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  rs_val,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  pc_inc8
);

  localparam int REGION_W = XLEN - TGT_W - WORD_SHIFT;
  localparam int SEXT_W   = XLEN - IMM_W - WORD_SHIFT;

  logic [XLEN-1:0] pc_inc4;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] abs_tgt;

  assign pc_inc4 = pc + XLEN'(4);
  assign pc_inc8 = pc + XLEN'(8);
  assign br_off  = {{SEXT_W{imm[IMM_W-1]}}, imm, {WORD_SHIFT{1'b0}}};
  assign br_tgt  = pc_inc4 + br_off;
  assign abs_tgt = {pc_inc4[XLEN-1 -: REGION_W], tgt, {WORD_SHIFT{1'b0}}};

  always_comb begin
    case (kind)
      FLOW_JABS, FLOW_JLINK: next_pc = abs_tgt;
      FLOW_JREG:             next_pc = rs_val;
      FLOW_BEQ, FLOW_BNE, FLOW_BLTZ, FLOW_BGEZ, FLOW_BLEZ, FLOW_BGTZ:
                             next_pc = taken ? br_tgt : pc_inc4;
      default:               next_pc = pc_inc4;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] START_ADDR = 32'h0040_0000,
  parameter int              LINK_REG   = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [INSN_W-1:0]    instr,
  input  logic [XLEN-1:0]      rs_val,
  input  logic [XLEN-1:0]      rt_val,
  output logic [XLEN-1:0]      pc,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]      link_val
);

  flow_e            kind;
  logic [TGT_W-1:0] tgt;
  logic [IMM_W-1:0] imm;
  logic             taken;
  logic [XLEN-1:0]  pc_d;
  logic [XLEN-1:0]  pc_q;
  logic [XLEN-1:0]  pc_inc8;
  logic             pc_en;

  npc_decode u_decode (
    .instr (instr),
    .kind  (kind),
    .tgt   (tgt),
    .imm   (imm)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind   (kind),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .taken  (taken)
  );

  npc_target #(.XLEN(XLEN)) u_target (
    .pc      (pc_q),
    .kind    (kind),
    .taken   (taken),
    .tgt     (tgt),
    .imm     (imm),
    .rs_val  (rs_val),
    .next_pc (pc_d),
    .pc_inc8 (pc_inc8)
  );

  // single-cycle core: the PC advances on every edge
  assign pc_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= START_ADDR;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc       = pc_q;
  assign link_we  = (kind == FLOW_JLINK);
  assign link_idx = REG_IDX_W'(LINK_REG);
  assign link_val = pc_inc8;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic [XLEN-1:0] pc,
  input logic            link_we,
  input logic [4:0]      link_idx,
  input logic [XLEN-1:0] link_val
);

  logic [5:0]      op;
  logic            is_jr;
  logic            is_ctl;
  logic [XLEN-1:0] nxt4;
  logic [XLEN-1:0] jexp;

  assign op     = instr[31:26];
  assign is_jr  = (op == 6'h00) && (instr[5:0] == 6'h08);
  assign is_ctl = is_jr || (op >= 6'h02 && op <= 6'h07) ||
                  (op == 6'h01 && instr[20:17] == 4'd0);
  assign nxt4   = pc + XLEN'(4);
  assign jexp   = {nxt4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ctl |=> pc == $past(nxt4));

  // R3
  jump_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h02) |=> pc == $past(jexp));

  // R4
  link_only_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we == (op == 6'h03));

  // R4
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx == 5'd31 && link_val == pc + XLEN'(8)));

  // R5
  jump_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_jr |=> pc == $past(rs_val));

  // R9
  eq_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h04 && rs_val != rt_val) |=> pc == $past(nxt4));

  // R10
  region_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h02 || op == 6'h03) |=> pc[XLEN-1:XLEN-4] == $past(nxt4[XLEN-1:XLEN-4]));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .pc       (pc),
  .link_we  (link_we),
  .link_idx (link_idx),
  .link_val (link_val)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

  localparam logic [31:0] START = 32'h0040_0000;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_val;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] cur_pc;

  npc_unit #(.START_ADDR(START)) u_npc_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .pc       (pc),
    .link_we  (link_we),
    .link_idx (link_idx),
    .link_val (link_val)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [15:0] imm);
    return {op, 5'd4, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] t);
    return {op, t};
  endfunction

  function automatic logic [31:0] enc_r(logic [5:0] fn);
    return {6'h00, 5'd3, 5'd2, 5'd1, 5'd0, fn};
  endfunction

  function automatic logic [31:0] br_dest(logic [31:0] p, logic [15:0] off);
    return p + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  function automatic logic [31:0] jmp_dest(logic [31:0] p, logic [25:0] t);
    logic [31:0] p4;
    p4 = p + 32'd4;
    return {p4[31:28], t, 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one instruction, check link outputs before the edge, PC after it
  task automatic run(string req, logic [31:0] ins, logic [31:0] rsv, logic [31:0] rtv,
                     logic [31:0] exp_pc, logic exp_we);
    @(negedge clk);
    instr  = ins;
    rs_val = rsv;
    rt_val = rtv;
    #1;
    chk({req, " link_we"}, {31'd0, link_we}, {31'd0, exp_we});
    if (exp_we) begin
      chk({req, " link_idx"}, {27'd0, link_idx}, 32'd31);
      chk({req, " link_val"}, link_val, cur_pc + 32'd8);
    end
    @(posedge clk);
    #1;
    chk({req, " pc"}, pc, exp_pc);
    cur_pc = exp_pc;
  endtask

  task automatic set_pc(logic [31:0] v);
    run("R5 setup", enc_r(6'h08), v, 32'd0, v, 1'b0);
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    instr  = 32'd0;
    rs_val = 32'd0;
    rt_val = 32'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", pc, START);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 after release", pc, START);
    cur_pc = START;
  endtask

  task automatic t_seq();
    set_pc(32'h0000_1000);
    run("R2 alu", enc_r(6'h20), 32'd5, 32'd5, 32'h0000_1004, 1'b0);
    run("R2 load", enc_i(6'h23, 5'd1, 16'h0004), 32'd0, 32'd0, 32'h0000_1008, 1'b0);
    run("R2 bad sub", enc_i(6'h01, 5'd5, 16'h0010), 32'hFFFF_FFFF, 32'd0, 32'h0000_100C, 1'b0);
  endtask

  task automatic t_jump();
    set_pc(32'h0000_1008);
    run("R3 jump", enc_j(6'h02, 26'h100_0001), 32'd0, 32'd0, jmp_dest(cur_pc, 26'h100_0001), 1'b0);
    chk("R3 value", cur_pc, 32'h0400_0004);
  endtask

  task automatic t_jal();
    set_pc(32'h1234_5670);
    run("R4 call", enc_j(6'h03, 26'h000_0040), 32'd0, 32'd0, jmp_dest(cur_pc, 26'h000_0040), 1'b1);
    chk("R4 call dest", cur_pc, 32'h1000_0100);
  endtask

  task automatic t_jr();
    set_pc(32'hABCD_1234);
    run("R5 reg jump", enc_r(6'h08), 32'hDECA_FE00, 32'd0, 32'hDECA_FE00, 1'b0);
  endtask

  task automatic t_eq();
    set_pc(32'h0000_2000);
    run("R6 eq taken", enc_i(6'h04, 5'd1, 16'd3), 32'd7, 32'd7, br_dest(cur_pc, 16'd3), 1'b0);
    chk("R6 eq dest", cur_pc, 32'h0000_2010);
    run("R9 ne equal", enc_i(6'h05, 5'd1, 16'd9), 32'd7, 32'd7, cur_pc + 32'd4, 1'b0);
    run("R6 ne taken neg", enc_i(6'h05, 5'd1, 16'hFFFE), 32'd7, 32'd8, br_dest(cur_pc, 16'hFFFE), 1'b0);
    run("R9 eq differ", enc_i(6'h04, 5'd1, 16'd5), 32'd1, 32'd2, cur_pc + 32'd4, 1'b0);
  endtask

  task automatic t_sign();
    set_pc(32'h0000_3000);
    run("R7 ltz neg", enc_i(6'h01, 5'd0, 16'd2), 32'h8000_0000, 32'd0, br_dest(cur_pc, 16'd2), 1'b0);
    run("R7 ltz zero", enc_i(6'h01, 5'd0, 16'd2), 32'd0, 32'd0, cur_pc + 32'd4, 1'b0);
    run("R7 gez zero", enc_i(6'h01, 5'd1, 16'd2), 32'd0, 32'd0, br_dest(cur_pc, 16'd2), 1'b0);
    run("R7 gez neg", enc_i(6'h01, 5'd1, 16'd2), 32'hFFFF_FFFF, 32'd0, cur_pc + 32'd4, 1'b0);
  endtask

  task automatic t_lez();
    set_pc(32'h0000_4000);
    run("R8 lez zero", enc_i(6'h06, 5'd0, 16'h0010), 32'd0, 32'd0, br_dest(cur_pc, 16'h0010), 1'b0);
    run("R8 lez pos", enc_i(6'h06, 5'd0, 16'h0010), 32'd1, 32'd0, cur_pc + 32'd4, 1'b0);
    run("R8 gtz pos", enc_i(6'h07, 5'd0, 16'hFFF0), 32'd1, 32'd0, br_dest(cur_pc, 16'hFFF0), 1'b0);
    run("R8 gtz minneg", enc_i(6'h07, 5'd0, 16'hFFF0), 32'h8000_0000, 32'd0, cur_pc + 32'd4, 1'b0);
  endtask

  task automatic t_region();
    set_pc(32'h2FFF_FFFC);
    run("R10 cross", enc_j(6'h02, 26'h000_0010), 32'd0, 32'd0, 32'h3000_0040, 1'b0);
    set_pc(32'h2FFF_FFF8);
    run("R10 stay", enc_j(6'h02, 26'h000_0010), 32'd0, 32'd0, 32'h2000_0040, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_seq();
    t_jump();
    t_jal();
    t_jr();
    t_eq();
    t_sign();
    t_lez();
    t_region();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule